// File: doc/BRIEF.md
# Programming Waveform Sequencer

This block drives the parallel code of an external DAC so that one control line carries a memory programming waveform. While idle the code rests at midscale, which stands for half the supply. A start strobe begins a write cycle. The code climbs to the programming level in equal steps, stays there for a fixed time, falls to zero along a short descending staircase, stays at zero, and then returns to midscale.

An external comparator reports whether the high-voltage stage has actually reached the programming level. The block samples that verify input at the last edge of the climb. If the level has not been reached, the cycle is cut short: the code goes straight back to midscale and an error flag is set.

All phase lengths are counted in ticks of a parameterised clock prescaler. The fall length and the zero-hold length are clamped to their permitted time windows, which are computed from the tick period.

Top module: `prog_wave_seq`

## Requirements
- R1: After reset, and whenever idle, `code_o` equals MID_CODE (default 128, midscale of an 8-bit code), and `busy_o`, `done_o` and `err_o` are low.
- R2: A `start_i` sampled high while idle sets `busy_o` at that edge, clears `err_o`, and moves `code_o` to MID_CODE+STEP_CODE.
- R3: The climb has RAMP_STEPS equal increments of STEP_CODE, one every STEP_TICKS ticks, and ends at TOP = MID_CODE + RAMP_STEPS*STEP_CODE after RAMP_STEPS*STEP_TICKS ticks (7.5 ms at the default 50 µs tick).
- R4: If `verify_i` is high at the edge that ends the climb, `code_o` stays at TOP for HOLD_TICKS ticks (1.0 ms at the default tick).
- R5: The fall never raises `code_o`. It starts at the edge that ends the hold and reaches 0 exactly F ticks later, where F is FALL_STEPS clamped to the range ceil(10 µs/tick) to floor(1000 µs/tick).
- R6: Zero is held for Z ticks, where Z = max(ZERO_TICKS, ceil(200 µs/tick)), and then `code_o` returns to MID_CODE.
- R7: On the edge that returns `code_o` to MID_CODE, `busy_o` falls and `done_o` is high for exactly one cycle.
- R8: If `verify_i` is low at the edge that ends the climb, then at that same edge `code_o` returns to MID_CODE, `err_o` rises and `done_o` pulses. The hold, fall and zero phases are skipped.
- R9: A `start_i` that arrives while busy has no effect on the waveform or on its timing.
- R10: `err_o` stays high until the next accepted start clears it.
- R11: One tick lasts TICK_DIV clock cycles, counted from the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a write cycle when idle |
| verify_i | input | 1 | Comparator: programming level reached |
| code_o | output | DAC_W | DAC code |
| busy_o | output | 1 | Write cycle in progress |
| done_o | output | 1 | One-cycle pulse on return to midscale |
| err_o | output | 1 | Verify failed at the end of the climb |

## Verification
The bench builds the block with TICK_DIV=2 and keeps the default tick counts, so the climb, hold, fall and zero phases keep their time ratios while a whole write cycle takes only 358 clocks. Every phase edge can then be checked at its exact clock cycle. A second instance is built with FALL_STEPS=40 and ZERO_TICKS=1. Both values lie outside the permitted windows, so that instance exercises the upper clamp on the fall and the lower clamp on the zero hold. The verify input is modelled as a threshold on the code. It can be held low to force the abort path.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_RAMP, PH_HOLD, PH_FALL, PH_ZERO} phase_e;

  localparam int FALL_MIN_US = 10;
  localparam int FALL_MAX_US = 1000;
  localparam int ZERO_MIN_US = 200;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int fall_ticks(input int req, input int tick_us);
    int lo;
    int hi;
    lo = ceil_div(FALL_MIN_US, tick_us);
    if (lo < 1) lo = 1;
    hi = FALL_MAX_US / tick_us;
    if (hi < lo) hi = lo;
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  function automatic int zero_ticks(input int req, input int tick_us);
    int lo;
    lo = ceil_div(ZERO_MIN_US, tick_us);
    if (lo < 1) lo = 1;
    return (req < lo) ? lo : req;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pws_tick.sv
module pws_tick #(
  parameter int DIV = 6250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = en_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!en_i || tick_o)   pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      a_r11_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
  import pws_pkg::*;
#(
  parameter int RAMP_STEPS = 50,
  parameter int STEP_TICKS = 3,
  parameter int HOLD_TICKS = 20,
  parameter int FALL_N     = 4,
  parameter int ZERO_N     = 5
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   verify_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   busy_o,
  output logic   done_o,
  output logic   err_o,
  output logic   ev_start_o,
  output logic   ev_step_o,
  output logic   ev_mid_o,
  output logic   ev_fall_o,
  output logic   ev_zero_o
);
  localparam int TMAX = max4(STEP_TICKS, HOLD_TICKS, FALL_N, ZERO_N);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int SW   = $clog2(RAMP_STEPS + 1);
  localparam logic [CW-1:0] STEP_L = CW'(STEP_TICKS - 1);
  localparam logic [CW-1:0] HOLD_L = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] FALL_L = CW'(FALL_N - 1);
  localparam logic [CW-1:0] ZERO_L = CW'(ZERO_N - 1);
  localparam logic [SW-1:0] RAMP_L = SW'(RAMP_STEPS - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic          done_q, err_q, err_d;
  logic          ev_abort, ev_finish;

  always_comb begin
    ph_d       = ph_q;
    tcnt_d     = tcnt_q;
    scnt_d     = scnt_q;
    err_d      = err_q;
    ev_start_o = 1'b0;
    ev_step_o  = 1'b0;
    ev_fall_o  = 1'b0;
    ev_zero_o  = 1'b0;
    ev_abort   = 1'b0;
    ev_finish  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d       = PH_RAMP;
        tcnt_d     = '0;
        scnt_d     = '0;
        err_d      = 1'b0;
        ev_start_o = 1'b1;
      end
      PH_RAMP: if (tick_i) begin
        if (tcnt_q == STEP_L) begin
          tcnt_d = '0;
          if (scnt_q == RAMP_L) begin
            // verify is judged only on the last climb edge
            if (verify_i) ph_d = PH_HOLD;
            else begin
              ph_d     = PH_IDLE;
              err_d    = 1'b1;
              ev_abort = 1'b1;
            end
          end else begin
            scnt_d    = scnt_q + 1'b1;
            ev_step_o = 1'b1;
          end
        end else tcnt_d = tcnt_q + 1'b1;
      end
      PH_HOLD: if (tick_i) begin
        if (tcnt_q == HOLD_L) begin
          ph_d      = PH_FALL;
          tcnt_d    = '0;
          ev_fall_o = 1'b1;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      PH_FALL: if (tick_i) begin
        if (tcnt_q == FALL_L) begin
          ph_d      = PH_ZERO;
          tcnt_d    = '0;
          ev_zero_o = 1'b1;
        end else begin
          tcnt_d    = tcnt_q + 1'b1;
          ev_fall_o = 1'b1;
        end
      end
      PH_ZERO: if (tick_i) begin
        if (tcnt_q == ZERO_L) begin
          ph_d      = PH_IDLE;
          tcnt_d    = '0;
          ev_finish = 1'b1;
        end else tcnt_d = tcnt_q + 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign ev_mid_o = ev_abort | ev_finish;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      tcnt_q <= '0;
      scnt_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      tcnt_q <= tcnt_d;
      scnt_q <= scnt_d;
      err_q  <= err_d;
      done_q <= ev_mid_o;
    end
  end

  assign phase_o = ph_q;
  assign busy_o  = (ph_q != PH_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o && !busy_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(ph_q == PH_IDLE && start_i)) |=> err_o);
endmodule

// File: rtl/pws_code.sv
module pws_code
  import pws_pkg::*;
#(
  parameter int DAC_W      = 8,
  parameter int MID_CODE   = 128,
  parameter int STEP_CODE  = 2,
  parameter int RAMP_STEPS = 50,
  parameter int FALL_N     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_start_i,
  input  logic             ev_step_i,
  input  logic             ev_mid_i,
  input  logic             ev_fall_i,
  input  logic             ev_zero_i,
  output logic [DAC_W-1:0] code_o
);
  localparam int TOP = MID_CODE + RAMP_STEPS * STEP_CODE;
  localparam logic [DAC_W-1:0] MID_C  = DAC_W'(MID_CODE);
  localparam logic [DAC_W-1:0] STEP_C = DAC_W'(STEP_CODE);
  // staircase decrement sized so the last fall tick lands on zero
  localparam logic [DAC_W-1:0] DEC_C  = DAC_W'(ceil_div(TOP, FALL_N + 1));

  logic [DAC_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (ev_mid_i)                    code_d = MID_C;
    else if (ev_start_i)             code_d = MID_C + STEP_C;
    else if (ev_step_i)              code_d = code_q + STEP_C;
    else if (ev_zero_i)              code_d = '0;
    else if (ev_fall_i)              code_d = (code_q > DEC_C) ? code_q - DEC_C : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= MID_C;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/prog_wave_seq.sv
module prog_wave_seq
  import pws_pkg::*;
#(
  parameter int DAC_W      = 8,
  parameter int MID_CODE   = 128,
  parameter int STEP_CODE  = 2,
  parameter int RAMP_STEPS = 50,
  parameter int STEP_TICKS = 3,
  parameter int HOLD_TICKS = 20,
  parameter int FALL_STEPS = 4,
  parameter int ZERO_TICKS = 5,
  parameter int TICK_US    = 50,
  parameter int TICK_DIV   = 6250
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             verify_i,
  output logic [DAC_W-1:0] code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int FALL_N = fall_ticks(FALL_STEPS, TICK_US);
  localparam int ZERO_N = zero_ticks(ZERO_TICKS, TICK_US);
  localparam logic [DAC_W-1:0] MID_C  = DAC_W'(MID_CODE);
  localparam logic [DAC_W-1:0] STEP_C = DAC_W'(STEP_CODE);
  localparam logic [DAC_W-1:0] TOP_C  = DAC_W'(MID_CODE + RAMP_STEPS * STEP_CODE);

  phase_e phase;
  logic   tick;
  logic   ev_start, ev_step, ev_mid, ev_fall, ev_zero;

  pws_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (busy_o),
    .tick_o(tick)
  );

  pws_ctrl #(
    .RAMP_STEPS(RAMP_STEPS),
    .STEP_TICKS(STEP_TICKS),
    .HOLD_TICKS(HOLD_TICKS),
    .FALL_N    (FALL_N),
    .ZERO_N    (ZERO_N)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .verify_i  (verify_i),
    .tick_i    (tick),
    .phase_o   (phase),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .ev_start_o(ev_start),
    .ev_step_o (ev_step),
    .ev_mid_o  (ev_mid),
    .ev_fall_o (ev_fall),
    .ev_zero_o (ev_zero)
  );

  pws_code #(
    .DAC_W     (DAC_W),
    .MID_CODE  (MID_CODE),
    .STEP_CODE (STEP_CODE),
    .RAMP_STEPS(RAMP_STEPS),
    .FALL_N    (FALL_N)
  ) u_code (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_start_i(ev_start),
    .ev_step_i (ev_step),
    .ev_mid_i  (ev_mid),
    .ev_fall_i (ev_fall),
    .ev_zero_i (ev_zero),
    .code_o    (code_o)
  );

  a_r1_idle_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_IDLE) |-> (code_o == MID_C));
  a_r3_ramp_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_RAMP) |=> (phase != PH_RAMP || code_o == $past(code_o)
                            || code_o == $past(code_o) + STEP_C));
  a_r4_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_HOLD) |-> (code_o == TOP_C));
  a_r5_fall_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FALL) |=> (code_o <= $past(code_o)));
  a_r6_zero_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_ZERO) |-> (code_o == '0));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && code_o == MID_C));
endmodule

// File: tb/prog_wave_seq_tb.sv
module prog_wave_seq_tb;
  localparam int DW   = 8;
  localparam int MID  = 128;
  localparam int SC   = 2;
  localparam int RS   = 50;
  localparam int ST   = 3;
  localparam int HT   = 20;
  localparam int DIV  = 2;
  localparam int TOP  = MID + RS * SC;      // 228
  localparam int RAMP_END = DIV * RS * ST;  // 300
  localparam int HOLD_END = RAMP_END + DIV * HT;  // 340
  // main instance: F=4, Z=5 ; clamp instance: F=20 (max 1000/50), Z=4 (min 200/50)
  localparam int A_ZERO = HOLD_END + DIV * 4;     // 348
  localparam int A_END  = A_ZERO + DIV * 5;       // 358
  localparam int B_ZERO = HOLD_END + DIV * 20;    // 380
  localparam int B_END  = B_ZERO + DIV * 4;       // 388
  localparam int TRACE  = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vfy_en = 1'b1;
  logic [DW-1:0] code_a, code_b;
  logic busy_a, done_a, err_a, busy_b, done_b, err_b;
  logic vfy_a, vfy_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int ca [TRACE];
  int cb [TRACE];
  bit ba [TRACE];
  bit bb [TRACE];
  bit da [TRACE];
  bit db [TRACE];
  bit ea [TRACE];
  bit eb [TRACE];

  always #4 clk = ~clk;

  assign vfy_a = vfy_en && (int'(code_a) >= TOP);
  assign vfy_b = vfy_en && (int'(code_b) >= TOP);

  prog_wave_seq #(.TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .verify_i(vfy_a),
    .code_o(code_a), .busy_o(busy_a), .done_o(done_a), .err_o(err_a)
  );

  prog_wave_seq #(.TICK_DIV(DIV), .FALL_STEPS(40), .ZERO_TICKS(1)) u_clamp (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .verify_i(vfy_b),
    .code_o(code_b), .busy_o(busy_b), .done_o(done_b), .err_o(err_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // trace index n = negedge after n-th posedge following the start edge
  task automatic run_trace(input bit poke);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < TRACE; n++) begin
      if (n > 0) @(negedge clk);
      if (poke) start = (n == 100);
      ca[n] = int'(code_a); cb[n] = int'(code_b);
      ba[n] = busy_a; bb[n] = busy_b;
      da[n] = done_a; db[n] = done_b;
      ea[n] = err_a;  eb[n] = err_b;
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset code", int'(code_a), MID);
    chk("R1 reset busy", int'(busy_a), 0);
    chk("R1 reset done", int'(done_a), 0);
    chk("R1 reset err", int'(err_a), 0);
  endtask

  task automatic t_normal;
    int inc;
    int odd;
    int rise;
    int dn;
    vfy_en = 1'b1;
    run_trace(1'b0);
    chk("R2 first step", ca[0], MID + SC);
    chk("R2 busy set", int'(ba[0]), 1);
    chk("R11 tick spacing pre", ca[DIV*ST-1], MID + SC);
    chk("R11 tick spacing post", ca[DIV*ST], MID + 2*SC);
    inc = 0; odd = 0;
    for (int n = 1; n < RAMP_END; n++) begin
      if (ca[n] == ca[n-1] + SC) inc++;
      else if (ca[n] != ca[n-1]) odd++;
    end
    chk("R3 step count", inc, RS - 1);
    chk("R3 unequal steps", odd, 0);
    chk("R3 top reached", ca[DIV*ST*(RS-1)], TOP);
    chk("R3 below top before", ca[DIV*ST*(RS-1)-1], TOP - SC);
    chk("R4 hold last", ca[HOLD_END-1], TOP);
    chk("R4 hold ended", int'(ca[HOLD_END] < TOP), 1);
    rise = 0;
    for (int n = HOLD_END; n <= A_ZERO; n++) if (ca[n] > ca[n-1]) rise++;
    chk("R5 fall rises", rise, 0);
    chk("R5 nonzero before", int'(ca[A_ZERO-1] != 0), 1);
    chk("R5 zero reached", ca[A_ZERO], 0);
    chk("R6 zero held", ca[A_END-1], 0);
    chk("R6 back to mid", ca[A_END], MID);
    chk("R7 busy before", int'(ba[A_END-1]), 1);
    chk("R7 busy cleared", int'(ba[A_END]), 0);
    dn = 0;
    for (int n = 0; n < TRACE; n++) dn += int'(da[n]);
    chk("R7 single done", dn, 1);
    chk("R7 done cycle", int'(da[A_END]), 1);
    chk("R8 no err", int'(ea[A_END]), 0);
    // clamp instance
    rise = 0;
    for (int n = HOLD_END; n <= B_ZERO; n++) if (cb[n] > cb[n-1]) rise++;
    chk("R5 clamp rises", rise, 0);
    chk("R5 clamp nonzero", int'(cb[B_ZERO-1] != 0), 1);
    chk("R5 clamp zero", cb[B_ZERO], 0);
    chk("R6 clamp held", cb[B_END-1], 0);
    chk("R6 clamp mid", cb[B_END], MID);
    chk("R7 clamp done", int'(db[B_END]), 1);
    chk("R7 clamp busy", int'(bb[B_END]), 0);
  endtask

  task automatic t_busy_start;
    vfy_en = 1'b1;
    run_trace(1'b1);
    chk("R9 ramp undisturbed", ca[110], MID + SC * (1 + 110 / (DIV*ST)));
    chk("R9 hold unchanged", ca[HOLD_END-1], TOP);
    chk("R9 end unchanged", int'(da[A_END]), 1);
    chk("R9 clamp end", int'(db[B_END]), 1);
  endtask

  task automatic t_abort;
    vfy_en = 1'b0;
    run_trace(1'b0);
    chk("R8 at top before", ca[RAMP_END-1], TOP);
    chk("R8 mid at abort", ca[RAMP_END], MID);
    chk("R8 err set", int'(ea[RAMP_END]), 1);
    chk("R8 done pulse", int'(da[RAMP_END]), 1);
    chk("R8 busy low", int'(ba[RAMP_END]), 0);
    chk("R8 no zero phase", ca[RAMP_END+20], MID);
    chk("R8 clamp err", int'(eb[RAMP_END]), 1);
    chk("R10 err held", int'(ea[TRACE-1]), 1);
    vfy_en = 1'b1;
  endtask

  task automatic t_recover;
    vfy_en = 1'b1;
    run_trace(1'b0);
    chk("R10 err cleared", int'(ea[0]), 0);
    chk("R10 runs to end", int'(da[A_END]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_busy_start();
    t_abort();
    t_recover();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule